// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between a local bus and an external link and rewrites each outbound request address. Software programs up to eight windows through a 32-bit register port. Each window carries a 64-bit match value, a 64-bit remap value, a 64-bit mask and a 32-bit actions word, and each 64-bit value is written as a low and a high word. A request address that falls inside an enabled window has its masked upper bits replaced by the window's remap bits. The address bits below the mask are kept. The window's actions word goes out with the result.

Requests that no enabled window claims pass through untranslated. They carry a separate default actions word, so plain memory traffic needs no window at all. The lookup is purely combinational. The request/response pair uses valid/ready, and back-pressure passes straight through. `req_ready` equals `rsp_ready` and `rsp_valid` equals `req_valid`. The response fields depend only on `req_addr` and the programmed registers, so they stay stable for as long as the requester holds its address while it waits for `rsp_ready`.

Top module: `addr_window_xlate`

## Requirements
- R1: The register block of window n (n = 0..7) starts at byte address 0x4C00 + 0x20*n. Inside it, 0x00/0x04 hold the match value low/high words, 0x08/0x0C the remap value, 0x10/0x14 the mask, and 0x18 the actions word. A read returns the value last written.
- R2: The default actions word lives at 0x4CFC. Writes to any other address, including offset 0x1C of windows 0..6, addresses outside 0x4C00..0x4CFF, and addresses not 4-byte aligned, change nothing, and reads from those addresses return 0.
- R3: Bits 15:0 of every mask are forced to zero on write (a read of mask low returns wdata AND 0xFFFF0000). Bits 15:0 of a translated address therefore always equal those of the request.
- R4: Bit 0 of the match-low word enables the window. A window with this bit clear never hits, whatever its other fields hold, and writing zero to all seven of its registers disables it.
- R5: Address A hits enabled window n when (A XOR match) AND mask is zero over all 64 bits.
- R6: On a hit, rsp_addr = (remap AND mask) OR (A AND NOT mask), and rsp_hit = 1.
- R7: When several enabled windows hit, the lowest-numbered one supplies the address and the actions word.
- R8: When no enabled window hits, rsp_hit = 0, rsp_addr = req_addr, and rsp_actions = the default actions word.
- R9: Reset clears every window and the default actions word to zero. After reset, every register reads 0 and every lookup misses with actions 0 (memory type).
- R10: A register write is sampled on the rising clock edge and affects lookups from that edge on, not before it. The lookup itself has no clock cycles of latency.
- R11: rsp_valid equals req_valid and req_ready equals rsp_ready in every cycle.
- R12: The actions word is returned unaltered. Its bits 3:0 give the type (0x0 memory, 0x4 I/O, 0x8 config type 0, 0x9 config type 1, 0xC message). Bit 11 enables the attributes, bits 10:8 hold the traffic class, and bits 7, 6, 5 and 4 are relaxed ordering, no-snoop, poison and ID-based ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Request accepted (follows rsp_ready) |
| req_addr | input | 64 | Local-bus address to translate |
| rsp_valid | output | 1 | Response valid (follows req_valid) |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_addr | output | 64 | Translated link address |
| rsp_actions | output | 32 | Actions word of the winning window, or the default |
| rsp_hit | output | 1 | An enabled window matched |

## Verification
The bench builds the block with its default parameters: eight windows, a 16-bit register address and a base of 0x4C00. With these values the real register map, the default-word slot at 0x4CFC and every window index can be reached. The address sweep steps across a 128 MiB range one 64 KiB granule at a time. Windows of 64 KiB, 64 MiB and 128 MiB overlap in that range, and one window sits above the 4 GiB line. As a result, every granule boundary, every priority overlap and the high-word compare all fall inside the range checked against the bench's own arithmetic model. The bench runs the sweep again after a window is cleared and again after a mid-run reset.

// File: rtl/obx_pkg.sv
package obx_pkg;

  localparam int OBX_AW          = 64;
  localparam int OBX_DW          = 32;
  localparam int OBX_GRAN        = 16;
  localparam int OBX_STRIDE_LOG2 = 5;

  typedef enum logic [2:0] {
    SLOT_MATCH_LO = 3'd0,
    SLOT_MATCH_HI = 3'd1,
    SLOT_REMAP_LO = 3'd2,
    SLOT_REMAP_HI = 3'd3,
    SLOT_MASK_LO  = 3'd4,
    SLOT_MASK_HI  = 3'd5,
    SLOT_ACTIONS  = 3'd6,
    SLOT_TAIL     = 3'd7
  } obx_slot_e;

  typedef struct packed {
    logic [OBX_AW-1:0] match;
    logic [OBX_AW-1:0] remap;
    logic [OBX_AW-1:0] mask;
    logic [OBX_DW-1:0] actions;
  } obx_win_t;

endpackage

// File: rtl/obx_reg_decode.sv
module obx_reg_decode
  import obx_pkg::*;
#(
  parameter int              NUM_WIN  = 8,
  parameter int              REG_AW   = 16,
  parameter logic [REG_AW-1:0] WIN_BASE = 16'h4C00,
  localparam int             WIN_W    = $clog2(NUM_WIN)
) (
  input  logic [REG_AW-1:0] addr,
  output logic              sel_win,
  output logic              sel_dflt,
  output logic [WIN_W-1:0]  win_idx,
  output obx_slot_e         slot
);

  localparam int SPAN = NUM_WIN << OBX_STRIDE_LOG2;

  logic [REG_AW-1:0] off;
  logic              in_map;

  always_comb begin
    off     = addr - WIN_BASE;
    in_map  = (addr >= WIN_BASE) && (32'(off) < 32'(SPAN)) && (off[1:0] == 2'b00);
    slot    = obx_slot_e'(off[OBX_STRIDE_LOG2-1:2]);
    win_idx = off[OBX_STRIDE_LOG2 +: WIN_W];
    sel_win  = in_map && (slot != SLOT_TAIL);
    sel_dflt = in_map && (slot == SLOT_TAIL) && (32'(win_idx) == 32'(NUM_WIN - 1));
  end

endmodule

// File: rtl/obx_win_bank.sv
module obx_win_bank
  import obx_pkg::*;
#(
  parameter int  NUM_WIN = 8,
  localparam int WIN_W   = $clog2(NUM_WIN)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [WIN_W-1:0]            wr_win,
  input  obx_slot_e                   wr_slot,
  input  logic [OBX_DW-1:0]           wdata,
  output obx_win_t [NUM_WIN-1:0]      wins_o
);

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    obx_win_t win_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_q <= '0;
      end else if (wr_en && (wr_win == WIN_W'(gi))) begin
        case (wr_slot)
          SLOT_MATCH_LO: win_q.match[31:0]  <= wdata;
          SLOT_MATCH_HI: win_q.match[63:32] <= wdata;
          SLOT_REMAP_LO: win_q.remap[31:0]  <= wdata;
          SLOT_REMAP_HI: win_q.remap[63:32] <= wdata;
          SLOT_MASK_LO:  win_q.mask[31:0]   <= {wdata[OBX_DW-1:OBX_GRAN], {OBX_GRAN{1'b0}}};
          SLOT_MASK_HI:  win_q.mask[63:32]  <= wdata;
          SLOT_ACTIONS:  win_q.actions      <= wdata;
          default:       win_q              <= win_q;
        endcase
      end
    end

    assign wins_o[gi] = win_q;
  end

endmodule

// File: rtl/obx_win_match.sv
module obx_win_match
  import obx_pkg::*;
(
  input  obx_win_t          win,
  input  logic [OBX_AW-1:0] addr,
  output logic              hit,
  output logic [OBX_AW-1:0] xaddr
);

  logic enabled;

  always_comb begin
    enabled = win.match[0];
    hit     = enabled && (((addr ^ win.match) & win.mask) == '0);
    xaddr   = (win.remap & win.mask) | (addr & ~win.mask);
  end

endmodule

// File: rtl/obx_prio_pick.sv
module obx_prio_pick #(
  parameter int  NUM_WIN = 8,
  localparam int WIN_W   = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0] hits,
  output logic               any,
  output logic [WIN_W-1:0]   idx
);

  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits[i]) idx = WIN_W'(i);
    end
  end

endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate
  import obx_pkg::*;
#(
  parameter int                NUM_WIN  = 8,
  parameter int                REG_AW   = 16,
  parameter logic [REG_AW-1:0] WIN_BASE = 16'h4C00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [15:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_addr,
  output logic [31:0]       rsp_actions,
  output logic              rsp_hit
);

  localparam int WIN_W = $clog2(NUM_WIN);

  logic                   sel_win;
  logic                   sel_dflt;
  logic [WIN_W-1:0]       dec_win;
  obx_slot_e              dec_slot;
  obx_win_t [NUM_WIN-1:0] wins;
  logic [OBX_DW-1:0]      dflt_actions_q;
  logic [NUM_WIN-1:0]     hits;
  logic [OBX_AW-1:0]      xaddrs [NUM_WIN];
  logic                   any_hit;
  logic [WIN_W-1:0]       win_sel;
  obx_win_t               rd_win;

  obx_reg_decode #(
    .NUM_WIN (NUM_WIN),
    .REG_AW  (REG_AW),
    .WIN_BASE(WIN_BASE)
  ) u_dec (
    .addr    (reg_addr[REG_AW-1:0]),
    .sel_win (sel_win),
    .sel_dflt(sel_dflt),
    .win_idx (dec_win),
    .slot    (dec_slot)
  );

  obx_win_bank #(
    .NUM_WIN(NUM_WIN)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en && sel_win),
    .wr_win (dec_win),
    .wr_slot(dec_slot),
    .wdata  (reg_wdata),
    .wins_o (wins)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dflt_actions_q <= '0;
    else if (reg_wr_en && sel_dflt) dflt_actions_q <= reg_wdata;
  end

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_match
    obx_win_match u_match (
      .win  (wins[gi]),
      .addr (req_addr),
      .hit  (hits[gi]),
      .xaddr(xaddrs[gi])
    );
  end

  obx_prio_pick #(
    .NUM_WIN(NUM_WIN)
  ) u_pick (
    .hits(hits),
    .any (any_hit),
    .idx (win_sel)
  );

  always_comb begin
    rsp_hit     = any_hit;
    rsp_addr    = any_hit ? xaddrs[win_sel] : req_addr;
    rsp_actions = any_hit ? wins[win_sel].actions : dflt_actions_q;
    rsp_valid   = req_valid;
    req_ready   = rsp_ready;
  end

  always_comb begin
    rd_win    = wins[dec_win];
    reg_rdata = '0;
    if (sel_dflt) begin
      reg_rdata = dflt_actions_q;
    end else if (sel_win) begin
      case (dec_slot)
        SLOT_MATCH_LO: reg_rdata = rd_win.match[31:0];
        SLOT_MATCH_HI: reg_rdata = rd_win.match[63:32];
        SLOT_REMAP_LO: reg_rdata = rd_win.remap[31:0];
        SLOT_REMAP_HI: reg_rdata = rd_win.remap[63:32];
        SLOT_MASK_LO:  reg_rdata = rd_win.mask[31:0];
        SLOT_MASK_HI:  reg_rdata = rd_win.mask[63:32];
        SLOT_ACTIONS:  reg_rdata = rd_win.actions;
        default:       reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/obx_xlate_chk.sv
module obx_xlate_chk #(
  parameter logic [15:0] DFLT_ADDR = 16'h4CFC
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [15:0] reg_addr,
  input logic [31:0] reg_wdata,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [63:0] rsp_addr,
  input logic [31:0] rsp_actions,
  input logic        rsp_hit,
  input logic [31:0] dflt_actions
);

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == req_valid);

  assert_ready_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == rsp_ready);

  assert_low_bits_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_addr[15:0] == req_addr[15:0]);

  assert_miss_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == req_addr && rsp_actions == dflt_actions));

  assert_dflt_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == DFLT_ADDR) |=> dflt_actions == $past(reg_wdata));

endmodule

bind addr_window_xlate obx_xlate_chk #(
  .DFLT_ADDR(16'(WIN_BASE + (NUM_WIN * 32) - 4))
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_en   (reg_wr_en),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_addr    (rsp_addr),
  .rsp_actions (rsp_actions),
  .rsp_hit     (rsp_hit),
  .dflt_actions(dflt_actions_q)
);

// File: tb/addr_window_xlate_bench.sv
module addr_window_xlate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic [31:0] rsp_actions;
  logic        rsp_hit;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [63:0] m_match [8];
  logic [63:0] m_remap [8];
  logic [63:0] m_mask  [8];
  logic [31:0] m_act   [8];
  logic [31:0] m_dflt;

  always #10 clk = ~clk;

  addr_window_xlate u_addr_window_xlate (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_actions(rsp_actions),
    .rsp_hit(rsp_hit)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) begin
      m_match[i] = '0; m_remap[i] = '0; m_mask[i] = '0; m_act[i] = '0;
    end
    m_dflt = '0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #2;
    check(tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic set_win(input int n, input logic [63:0] mt, input logic [63:0] rm,
                         input logic [63:0] mk, input logic [31:0] ac);
    logic [15:0] b;
    b = 16'h4C00 + 16'(n * 32);
    wr(b + 16'h00, mt[31:0]); wr(b + 16'h04, mt[63:32]);
    wr(b + 16'h08, rm[31:0]); wr(b + 16'h0C, rm[63:32]);
    wr(b + 16'h10, mk[31:0]); wr(b + 16'h14, mk[63:32]);
    wr(b + 16'h18, ac);
    m_match[n] = mt; m_remap[n] = rm; m_mask[n] = {mk[63:16], 16'h0}; m_act[n] = ac;
  endtask

  task automatic readback_win(input int n);
    logic [15:0] b;
    b = 16'h4C00 + 16'(n * 32);
    rd_chk("R1 match lo", b + 16'h00, m_match[n][31:0]);
    rd_chk("R1 match hi", b + 16'h04, m_match[n][63:32]);
    rd_chk("R1 remap lo", b + 16'h08, m_remap[n][31:0]);
    rd_chk("R1 remap hi", b + 16'h0C, m_remap[n][63:32]);
    rd_chk("R3 mask lo forced", b + 16'h10, m_mask[n][31:0]);
    rd_chk("R1 mask hi", b + 16'h14, m_mask[n][63:32]);
    rd_chk("R12 actions", b + 16'h18, m_act[n]);
  endtask

  task automatic lookup(input string tag, input logic [63:0] a);
    logic [63:0] ea;
    logic [31:0] eact;
    logic        eh;
    @(negedge clk);
    req_addr = a;
    req_valid = 1'b1;
    ea = a; eact = m_dflt; eh = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      if (m_match[i][0] && (((a ^ m_match[i]) & m_mask[i]) == 64'h0)) begin
        eh = 1'b1;
        ea = (m_remap[i] & m_mask[i]) | (a & ~m_mask[i]);
        eact = m_act[i];
      end
    end
    #2;
    check({tag, " addr"}, rsp_addr, ea);
    if (rsp_actions !== eact || rsp_hit !== eh) begin
      check({tag, " act/hit"}, {31'h0, rsp_hit, rsp_actions}, {31'h0, eh, eact});
    end
  endtask

  task automatic sweep(input string tag);
    for (logic [63:0] a = 64'hE7F0_0000; a <= 64'hF001_0000; a += 64'h1_0000) begin
      lookup(tag, a | 64'((a[31:16] * 16'h1234) & 16'hFFFF));
    end
    lookup({tag, " hi R5"}, 64'h0000_0001_0000_ABCD);
    lookup({tag, " hi miss R5"}, 64'h0000_0002_0000_ABCD);
    lookup({tag, " win7 off R4"}, 64'h0000_0000_F000_0010);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    rd_chk("R9 reset match lo w0", 16'h4C00, 32'h0);
    rd_chk("R9 reset actions w7", 16'h4CF8, 32'h0);
    rd_chk("R9 reset default", 16'h4CFC, 32'h0);
    lookup("R9 reset lookup miss", 64'h1234_5678_9ABC_DEF0);

    // R11: handshake pass-through
    @(negedge clk); rsp_ready = 1'b0; req_valid = 1'b1; #2;
    check("R11 ready low", 64'(req_ready), 64'h0);
    check("R11 valid high", 64'(rsp_valid), 64'h1);
    @(negedge clk); rsp_ready = 1'b1; req_valid = 1'b0; #2;
    check("R11 ready high", 64'(req_ready), 64'h1);
    check("R11 valid low", 64'(rsp_valid), 64'h0);

    // Program windows (R1, R12)
    set_win(0, 64'h0000_0000_E800_0001, 64'h0000_0012_3400_0000, 64'hFFFF_FFFF_FC00_0000, 32'h0000_0880);
    set_win(1, 64'h0000_0000_E800_0001, 64'h0000_0000_4000_0000, 64'hFFFF_FFFF_F800_0000, 32'h0000_0150);
    set_win(3, 64'h0000_0000_EFFF_0001, 64'h0000_00AB_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0004);
    set_win(5, 64'h0000_0001_0000_0001, 64'h0000_0000_C000_0000, 64'hFFFF_FFFF_FFFF_0000, 32'h0000_0009);
    set_win(7, 64'h0000_0000_F000_0000, 64'h0000_0000_1000_0000, 64'hFFFF_FFFF_FFFF_0000, 32'h0000_000C);
    m_dflt = 32'h0000_0008;
    wr(16'h4CFC, m_dflt);
    readback_win(0); readback_win(3); readback_win(7);
    rd_chk("R2 default readback", 16'h4CFC, m_dflt);

    // R2: ignored addresses
    wr(16'h4C1C, 32'hDEAD_BEEF); wr(16'h4C02, 32'hDEAD_BEEF);
    wr(16'h4BFC, 32'hDEAD_BEEF); wr(16'h4D00, 32'hDEAD_BEEF);
    rd_chk("R2 gap slot", 16'h4C1C, 32'h0);
    rd_chk("R2 unaligned", 16'h4C02, 32'h0);
    rd_chk("R2 below", 16'h4BFC, 32'h0);
    rd_chk("R2 above", 16'h4D00, 32'h0);
    readback_win(0);
    rd_chk("R2 default intact", 16'h4CFC, m_dflt);

    // R5 R6 R7 R8 R3 R12
    sweep("R7 sweep A");

    // R4: zeroing a window disables it
    set_win(1, 64'h0, 64'h0, 64'h0, 32'h0);
    readback_win(1);
    sweep("R4 sweep B");

    // R10: write visible only after the edge
    req_addr = 64'h0000_0000_0000_5555;
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 16'h4CFC; reg_wdata = 32'h0000_0F0C;
    #2;
    check("R10 before edge", 64'(rsp_actions), 64'(m_dflt));
    @(posedge clk); #2;
    check("R10 after edge", 64'(rsp_actions), 64'h0000_0F0C);
    @(negedge clk); reg_wr_en = 1'b0; m_dflt = 32'h0000_0F0C;

    // R9: mid-run reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model_clear();
    readback_win(0); readback_win(5);
    rd_chk("R9 default cleared", 16'h4CFC, 32'h0);
    lookup("R9 after reset", 64'h0000_0000_E800_1234);
    lookup("R9 after reset hi", 64'h0000_0001_0000_ABCD);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule